// File: doc/BRIEF.md
# USB Interrupt Aggregator

This block gathers interrupt events from a USB OTG controller and presents them to a host processor through a small 32-bit register window. Endpoint events and core events each collect in their own 32-bit pending word. Each pending word has a write-one-to-set alias, a write-one-to-clear alias, an enable word with its own set and clear aliases, and a read-only view of the pending bits that are enabled. Software uses the set alias to inject an interrupt without any hardware event.

A single interrupt output pulses for one cycle when an enabled pending bit is present and the line is armed. Each pulse disarms the line. Software handles the event, clears what it serviced, and writes any value to the end-of-interrupt address to arm the line again. A control register provides a self-clearing soft reset, a constant identification word reads back as nonzero, and a status word reports the level of the VBUS-drive input.

Top module: `usb_irq_glue`

## Requirements
- R1: Address 0x00 reads the nonzero parameter REV_ID (default 0x0002_0100). The reserved addresses 0x10 and 0x5C, and any unmapped address, read zero, and writes to them have no effect.
- R2: A high bit on `ep_evt` during a cycle makes the matching endpoint pending bit (read at 0x20) set from the next cycle. Only bits 31:17 and 15:0 of the endpoint word can become pending, so its pending word stays inside 0xFFFE_FFFF.
- R3: The core pending word (read at 0x40) holds only bits 24:16, so it stays inside 0x01FF_0000. Bit 24 is the VBUS-drive event, and it latches from `core_evt[24]` like the other bits.
- R4: Writing ones to 0x24 or 0x44 sets those pending bits, and writing ones to 0x28 or 0x48 clears them. When a clear write and a hardware event hit the same bit in the same cycle, the bit stays pending.
- R5: Writing ones to 0x30 or 0x50 sets enable bits, and writing ones to 0x34 or 0x54 clears them. The enable words read at 0x2C and 0x4C. The masked views at 0x38 and 0x58 read the pending word ANDed with its enable word.
- R6: When the line is armed and either masked view is nonzero at a clock edge, `irq` is high for exactly the following cycle and the line then disarms. While the line is disarmed, `irq` stays low whatever becomes pending.
- R7: A write of any value to 0x60 arms the line. If a masked bit is still pending, `irq` pulses in the cycle after the one in which the armed state becomes visible.
- R8: Writing 1 to bit 0 of the control register at 0x04 makes that bit read 1 for one cycle. Then both pending words and both enable words clear, the line re-arms, and the bit reads 0.
- R9: Bit 0 of the status word at 0x08 follows the `vbus_drv` input with one cycle of delay. Writes to 0x00, 0x08, 0x38 and 0x58 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| ep_evt | input | 32 | Endpoint event pulses, one bit per endpoint direction |
| core_evt | input | 32 | Core event pulses, with bits 24:16 used |
| vbus_drv | input | 1 | VBUS-drive level from the controller |
| irq | output | 1 | Interrupt pulse to the host |

## Verification
The bench drives an event and a clear write onto the same bit in the same cycle. A design that gives the clear priority would lose that event without a trace. The bench also raises new events while the line is disarmed and expects silence until the end-of-interrupt write. A design that re-fires on level would flood the host, and one that ignores the end-of-interrupt write would hang it. It writes all ones to the set aliases, which exposes any endpoint bit 16 or core bit outside 24:16 that becomes pending. It also checks that a soft reset re-arms the line with no end-of-interrupt write. A design that only clears the sources would stay silent on the next event.

// File: rtl/usb_irq_glue_pkg.sv
package usb_irq_glue_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_GRP  = 2;

  localparam logic [ADDR_W-1:0] OFS_REV  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h60;

  localparam logic [ADDR_W-1:0] EP_BASE   = 8'h20;
  localparam logic [ADDR_W-1:0] CORE_BASE = 8'h40;

  // offsets inside one event group
  localparam logic [ADDR_W-1:0] REL_SRC     = 8'h00;
  localparam logic [ADDR_W-1:0] REL_SRC_SET = 8'h04;
  localparam logic [ADDR_W-1:0] REL_SRC_CLR = 8'h08;
  localparam logic [ADDR_W-1:0] REL_MSK     = 8'h0C;
  localparam logic [ADDR_W-1:0] REL_MSK_SET = 8'h10;
  localparam logic [ADDR_W-1:0] REL_MSK_CLR = 8'h14;
  localparam logic [ADDR_W-1:0] REL_MASKED  = 8'h18;

  // implemented bits per group: endpoint bit 16 is absent, core uses 24:16
  localparam logic [DATA_W-1:0] EP_VALID   = 32'hFFFE_FFFF;
  localparam logic [DATA_W-1:0] CORE_VALID = 32'h01FF_0000;

  function automatic logic [ADDR_W-1:0] grp_base(input int g);
    return (g == 0) ? EP_BASE : CORE_BASE;
  endfunction

  function automatic logic [DATA_W-1:0] grp_valid(input int g);
    return (g == 0) ? EP_VALID : CORE_VALID;
  endfunction
endpackage

// File: rtl/usb_irq_rst_sync.sv
module usb_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/usb_irq_group.sv
module usb_irq_group #(
  parameter int unsigned W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] src_set_i,
  input  logic [W-1:0] src_clr_i,
  input  logic [W-1:0] msk_set_i,
  input  logic [W-1:0] msk_clr_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] msk_o,
  output logic [W-1:0] masked_o
);
  logic [W-1:0] src_q, src_d;
  logic [W-1:0] msk_q, msk_d;
  logic         src_en, msk_en;

  assign src_en = srst_i | (|evt_i) | (|src_set_i) | (|src_clr_i);
  assign msk_en = srst_i | (|msk_set_i) | (|msk_clr_i);

  always_comb begin
    if (srst_i) begin
      src_d = '0;
      msk_d = '0;
    end else begin
      // hardware event is merged after the clear, so it wins
      src_d = (((src_q | src_set_i) & ~src_clr_i) | evt_i) & VALID;
      msk_d = ((msk_q | msk_set_i) & ~msk_clr_i) & VALID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      msk_q <= '0;
    end else begin
      if (src_en) src_q <= src_d;
      if (msk_en) msk_q <= msk_d;
    end
  end

  assign src_o    = src_q;
  assign msk_o    = msk_q;
  assign masked_o = src_q & msk_q;

  assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_i && |(evt_i & VALID)) |=>
      ((src_q & $past(evt_i & VALID)) == $past(evt_i & VALID)));

  assert_clr_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst_i && |(src_clr_i & ~evt_i)) |=>
      ((src_q & $past(src_clr_i & ~evt_i)) == '0));

  assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (src_q == '0 && msk_q == '0));
endmodule

// File: rtl/usb_irq_line.sv
module usb_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_i,
  input  logic eoi_i,
  input  logic pend_i,
  output logic irq_o
);
  logic armed_q, armed_d;
  logic irq_q, irq_d;

  always_comb begin
    armed_d = armed_q;
    irq_d   = 1'b0;
    if (srst_i || eoi_i) begin
      armed_d = 1'b1;
    end else if (armed_q && pend_i) begin
      armed_d = 1'b0;
      irq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o = irq_q;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_quiet_disarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !eoi_i && !srst_i) |=> !irq_o);

  assert_srst_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (armed_q && !irq_o));
endmodule

// File: rtl/usb_irq_glue.sv
module usb_irq_glue
  import usb_irq_glue_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h0002_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] ep_evt,
  input  logic [31:0] core_evt,
  input  logic        vbus_drv,
  output logic        irq
);
  logic rst_s;
  logic ctrl_q, ctrl_d;
  logic vbus_q;
  logic eoi_wr;
  logic pend_any;

  logic [DATA_W-1:0] evt_w    [NUM_GRP];
  logic [DATA_W-1:0] src_w    [NUM_GRP];
  logic [DATA_W-1:0] msk_w    [NUM_GRP];
  logic [DATA_W-1:0] masked_w [NUM_GRP];
  logic [NUM_GRP-1:0] grp_pend;

  usb_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  assign evt_w[0] = ep_evt;
  assign evt_w[1] = core_evt;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] BASE = grp_base(g);
    logic [DATA_W-1:0] s_set, s_clr, m_set, m_clr;

    assign s_set = (bus_wr && bus_addr == BASE + REL_SRC_SET) ? bus_wdata : '0;
    assign s_clr = (bus_wr && bus_addr == BASE + REL_SRC_CLR) ? bus_wdata : '0;
    assign m_set = (bus_wr && bus_addr == BASE + REL_MSK_SET) ? bus_wdata : '0;
    assign m_clr = (bus_wr && bus_addr == BASE + REL_MSK_CLR) ? bus_wdata : '0;

    usb_irq_group #(.W(DATA_W), .VALID(grp_valid(g))) u_group (
      .clk       (clk),
      .rst_n     (rst_s),
      .srst_i    (ctrl_q),
      .evt_i     (evt_w[g]),
      .src_set_i (s_set),
      .src_clr_i (s_clr),
      .msk_set_i (m_set),
      .msk_clr_i (m_clr),
      .src_o     (src_w[g]),
      .msk_o     (msk_w[g]),
      .masked_o  (masked_w[g])
    );

    assign grp_pend[g] = |masked_w[g];
  end

  assign pend_any = |grp_pend;
  assign eoi_wr   = bus_wr && (bus_addr == OFS_EOI);

  usb_irq_line u_line (
    .clk    (clk),
    .rst_n  (rst_s),
    .srst_i (ctrl_q),
    .eoi_i  (eoi_wr),
    .pend_i (pend_any),
    .irq_o  (irq)
  );

  // soft reset bit: lives exactly one cycle after the write
  assign ctrl_d = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= 1'b0;
      vbus_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      vbus_q <= vbus_drv;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_REV:  bus_rdata = REV_ID;
      OFS_CTRL: bus_rdata = {31'd0, ctrl_q};
      OFS_STAT: bus_rdata = {31'd0, vbus_q};
      default:  bus_rdata = '0;
    endcase
    for (int g = 0; g < NUM_GRP; g++) begin
      if (bus_addr == grp_base(g) + REL_SRC ||
          bus_addr == grp_base(g) + REL_SRC_SET ||
          bus_addr == grp_base(g) + REL_SRC_CLR)
        bus_rdata = src_w[g];
      if (bus_addr == grp_base(g) + REL_MSK ||
          bus_addr == grp_base(g) + REL_MSK_SET ||
          bus_addr == grp_base(g) + REL_MSK_CLR)
        bus_rdata = msk_w[g];
      if (bus_addr == grp_base(g) + REL_MASKED)
        bus_rdata = masked_w[g];
    end
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr == 8'h10 || bus_addr == 8'h5C) |-> (bus_rdata == '0));

  assert_ctrl_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (ctrl_q && !(bus_wr && bus_addr == OFS_CTRL)) |=> !ctrl_q);
endmodule

// File: tb/usb_irq_glue_test.sv
module usb_irq_glue_test;
  localparam logic [31:0] REV = 32'h0002_0100;

  localparam logic [2:0] OP_IDLE = 3'd0;
  localparam logic [2:0] OP_WR   = 3'd1;
  localparam logic [2:0] OP_RD   = 3'd2;
  localparam logic [2:0] OP_EVE  = 3'd3;
  localparam logic [2:0] OP_EVC  = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  8'h00, REV,          4'd1}, // R1 identification
    '{OP_WR,  8'h00, 32'h0,        4'd9}, // R9 read-only write
    '{OP_RD,  8'h00, REV,          4'd9},
    '{OP_WR,  8'h10, 32'hFFFFFFFF, 4'd1}, // R1 reserved
    '{OP_RD,  8'h10, 32'h0,        4'd1},
    '{OP_WR,  8'h24, 32'hFFFFFFFF, 4'd2}, // R2 set alias, bit 16 absent
    '{OP_RD,  8'h20, 32'hFFFEFFFF, 4'd2},
    '{OP_WR,  8'h28, 32'hFFFFFFFF, 4'd4}, // R4 clear alias
    '{OP_RD,  8'h20, 32'h0,        4'd4},
    '{OP_WR,  8'h44, 32'hFFFFFFFF, 4'd3}, // R3 core field only
    '{OP_RD,  8'h40, 32'h01FF0000, 4'd3},
    '{OP_WR,  8'h48, 32'h00FF0000, 4'd4},
    '{OP_RD,  8'h40, 32'h01000000, 4'd4},
    '{OP_WR,  8'h50, 32'hFFFFFFFF, 4'd5}, // R5 enable set
    '{OP_RD,  8'h4C, 32'h01FF0000, 4'd5},
    '{OP_RD,  8'h58, 32'h01000000, 4'd5},
    '{OP_WR,  8'h54, 32'h01000000, 4'd5}, // R5 enable clear
    '{OP_RD,  8'h58, 32'h0,        4'd5},
    '{OP_RD,  8'h4C, 32'h00FF0000, 4'd5},
    '{OP_EVE, 8'h00, 32'h00010003, 4'd2}, // R2 hardware event
    '{OP_RD,  8'h20, 32'h00000003, 4'd2},
    '{OP_WR,  8'h38, 32'hFFFFFFFF, 4'd9}, // R9 masked view read-only
    '{OP_RD,  8'h20, 32'h00000003, 4'd9},
    '{OP_RD,  8'h38, 32'h0,        4'd5},
    '{OP_EVC, 8'h00, 32'h80000001, 4'd3}, // R3 outside field
    '{OP_RD,  8'h40, 32'h01000000, 4'd3},
    '{OP_WR,  8'h08, 32'h1,        4'd9}, // R9 status read-only
    '{OP_RD,  8'h08, 32'h0,        4'd9},
    '{OP_WR,  8'h5C, 32'hFFFFFFFF, 4'd1}, // R1 reserved
    '{OP_RD,  8'h5C, 32'h0,        4'd1},
    '{OP_WR,  8'h04, 32'h1,        4'd8}, // R8 soft reset
    '{OP_RD,  8'h04, 32'h1,        4'd8},
    '{OP_IDLE,8'h00, 32'h0,        4'd8},
    '{OP_RD,  8'h04, 32'h0,        4'd8},
    '{OP_RD,  8'h20, 32'h0,        4'd8},
    '{OP_RD,  8'h40, 32'h0,        4'd8},
    '{OP_RD,  8'h4C, 32'h0,        4'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] ep_evt;
  logic [31:0] core_evt;
  logic        vbus_drv;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  usb_irq_glue #(.REV_ID(REV)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ep_evt    (ep_evt),
    .core_evt  (core_evt),
    .vbus_drv  (vbus_drv),
    .irq       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse_ep(input logic [31:0] v);
    @(negedge clk); ep_evt = v;
    @(negedge clk); ep_evt = '0;
  endtask

  task automatic pulse_core(input logic [31:0] v);
    @(negedge clk); core_evt = v;
    @(negedge clk); core_evt = '0;
  endtask

  task automatic irq_is(input logic exp, input string req);
    #1;
    check(req, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    ep_evt = '0; core_evt = '0; vbus_drv = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    irq_is(1'b0, "R6 reset");
    bus_read(8'h20, 32'h0, "R2 reset");
    bus_read(8'h4C, 32'h0, "R5 reset");
    bus_read(8'h04, 32'h0, "R8 reset");

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   bus_write(VECS[i].addr, VECS[i].data);
        OP_RD:   bus_read(VECS[i].addr, VECS[i].data, $sformatf("R%0d vec %0d", VECS[i].req, i));
        OP_EVE:  pulse_ep(VECS[i].data);
        OP_EVC:  pulse_core(VECS[i].data);
        default: @(negedge clk);
      endcase
    end

    // R6: one pulse, then silence while disarmed
    bus_write(8'h30, 32'h1);
    pulse_ep(32'h1);
    irq_is(1'b0, "R6 latch cycle");
    @(negedge clk); irq_is(1'b1, "R6 pulse");
    @(negedge clk); irq_is(1'b0, "R6 pulse end");
    pulse_ep(32'h1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); irq_is(1'b0, "R6 disarmed");
    end

    // R7: end-of-interrupt re-arms and re-evaluates
    bus_write(8'h60, 32'h1234);
    irq_is(1'b0, "R7 arm cycle");
    @(negedge clk); irq_is(1'b1, "R7 refire");
    @(negedge clk); irq_is(1'b0, "R7 refire end");
    bus_write(8'h28, 32'h1);
    bus_write(8'h60, 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); irq_is(1'b0, "R7 nothing pending");
    end

    // R4: event and clear on the same bit in the same cycle
    @(negedge clk);
    ep_evt = 32'h20; bus_addr = 8'h28; bus_wdata = 32'h20; bus_wr = 1'b1;
    @(negedge clk);
    ep_evt = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_read(8'h20, 32'h20, "R4 event beats clear");
    bus_write(8'h28, 32'h20);
    bus_read(8'h20, 32'h0, "R4 clear");

    // R3: VBUS-drive event on bit 24 through the core group
    pulse_core(32'h0100_0000);
    bus_read(8'h40, 32'h0100_0000, "R3 vbus event");
    irq_is(1'b0, "R3 not enabled");
    bus_write(8'h50, 32'h0100_0000);
    irq_is(1'b0, "R3 enable cycle");
    @(negedge clk); irq_is(1'b1, "R3 core irq");
    bus_read(8'h58, 32'h0100_0000, "R5 core masked");

    // R8: soft reset re-arms with no end-of-interrupt write
    bus_write(8'h04, 32'h1);
    @(negedge clk);
    bus_read(8'h40, 32'h0, "R8 core cleared");
    bus_read(8'h2C, 32'h0, "R8 enable cleared");
    bus_write(8'h30, 32'h4);
    pulse_ep(32'h4);
    @(negedge clk); irq_is(1'b1, "R8 re-armed");

    // R9: status follows the VBUS-drive input
    vbus_drv = 1'b1;
    @(negedge clk);
    bus_read(8'h08, 32'h1, "R9 vbus high");
    vbus_drv = 1'b0;
    @(negedge clk);
    bus_read(8'h08, 32'h0, "R9 vbus low");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule